// File: doc/BRIEF.md
# Fractional-N Main Feedback Divider Controller

This block is the programmable main feedback divider of a frequency synthesizer that uses an external multi-modulus prescaler. It is clocked by the prescaler output, so one clock is one divider input cycle. A main cycle is split into up to four segments. A signed counter steps through them, and each segment drives a two-bit modulus-control code that picks the prescaler ratio for that stretch of input cycles. When a main cycle completes, the block emits a one-cycle pulse toward the phase detector.

That same pulse adds a programmed numerator to a fractional accumulator that wraps at 5 or 8. When the accumulator wraps, the next main cycle moves one input cycle from segment one into segment two. If the second ratio is one more than the first, the mean division ratio becomes N + NF/Q. The accumulator contents are exported so that a downstream block can compensate the phase ripple.

New settings arrive as one word on a valid/ready port and are held in a pending stage. They reach the working registers only at a main cycle boundary. The ready signal is low while a setting is pending and while the final segment of a cycle runs. The source must hold `cfg_valid` and the word stable until it sees `cfg_ready` high at a clock edge.

Top module: `fracn_main_div`

## Requirements
- R1: Synchronous active-high reset gives `mod_ctl` = 00, `div_pulse` = 0, `frd` = 0, `sync_win` = 0 and `cfg_ready` = 1 while `en` is low.
- R2: Segment one drives `mod_ctl` = 2'b10 (bit 1 is the first control line, bit 0 the second). It lasts NM1+2 input cycles when no cycle is stolen.
- R3: Segment two drives `mod_ctl` = 2'b00 and lasts NM2 input cycles, with NM2 at least 1. All 8 bits of NM2 count when PR = 2'b01. For any other PR, only NM2[3:0] counts.
- R4: When PR[1] = 1, segment three follows with `mod_ctl` = 2'b01 for NM3+1 input cycles. Otherwise it is absent.
- R5: When PR is 2'b11 or 2'b00, a last segment with `mod_ctl` = 2'b11 runs for NM4+1 input cycles. Otherwise it is absent.
- R6: `div_pulse` is high for exactly one input cycle per main cycle, in the last cycle of the final segment. The next main cycle starts in segment one right after it.
- R7: On each `div_pulse`, the accumulator adds NF modulo Q, where Q = 8 if `cfg_fmod` = 1 and 5 otherwise, with NF < Q. `frd` shows the sum from the clock after the pulse onward.
- R8: When the add wraps, the next main cycle has one fewer segment-one cycle and one more segment-two cycle.
- R9: With ratios R2 = R1+1, any Q consecutive main cycles that follow the first one divide by Q·N + NF in total. N is the ratio with no stolen cycle.
- R10: An accepted setting takes effect at the next main cycle boundary, or at once while idle. `sync_win` is high throughout the final segment, and `cfg_ready` is low then.
- R11: With `en` low, the counter idles from the next clock: `mod_ctl` = 00 and no pulse. Raising `en` starts a full main cycle in segment one. The accumulator is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (prescaler output) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider enable |
| cfg_valid | input | 1 | Setting word offered |
| cfg_ready | output | 1 | Setting word can be taken |
| cfg_nm1 | input | 12 | Segment-one length |
| cfg_nm2 | input | 8 | Segment-two length |
| cfg_nm3 | input | 4 | Segment-three length |
| cfg_nm4 | input | 4 | Final-segment length |
| cfg_pr | input | 2 | Segment layout select |
| cfg_nf | input | 3 | Fraction numerator |
| cfg_fmod | input | 1 | Modulus select: 1 gives 8, 0 gives 5 |
| mod_ctl | output | 2 | Prescaler modulus-control code |
| div_pulse | output | 1 | End-of-main-cycle pulse |
| frd | output | 3 | Fractional accumulator contents |
| sync_win | output | 1 | Final segment running; loading blocked |

## Verification
Integer settings are applied under all four layout codes, including an 8-bit NM2 above 15 that only the two-segment layout may count in full. This separates errors in segment length, segment presence and field width. Fractional runs with modulus 5 and modulus 8 confirm the cycle-stealing pattern and the accumulator value one cycle at a time, and the weighted total over Q cycles confirms the mean ratio. A setting written in the middle of a cycle must leave that cycle unchanged and govern the next one, which shows that loading waits for the boundary. An enable drop must silence the outputs and restart with a full segment one.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  parameter int NM1_W = 12;
  parameter int NM2_W = 8;
  parameter int NMS_W = 4;
  parameter int NF_W  = 3;

  localparam int CNT_W = NM1_W + 1;
  localparam int Q_W   = NF_W + 1;
  localparam logic [Q_W-1:0] Q_FINE   = Q_W'(8);
  localparam logic [Q_W-1:0] Q_COARSE = Q_W'(5);

  typedef enum logic [2:0] {SEG_IDLE, SEG_1, SEG_2, SEG_3, SEG_4} seg_e;

  typedef struct packed {
    logic [NM1_W-1:0] nm1;
    logic [NM2_W-1:0] nm2;
    logic [NMS_W-1:0] nm3;
    logic [NMS_W-1:0] nm4;
    logic [1:0]       pr;
    logic [NF_W-1:0]  nf;
    logic             fmod;
  } div_cfg_t;

  localparam div_cfg_t CFG_RST = '{nm1: '0, nm2: NM2_W'(1), nm3: '0, nm4: '0,
                                   pr: 2'b01, nf: '0, fmod: 1'b0};
endpackage

// File: rtl/fnd_cfg_stage.sv
module fnd_cfg_stage
  import fnd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  div_cfg_t in_cfg,
  input  logic     in_valid,
  output logic     in_ready,
  input  logic     apply_ok,
  input  logic     blocked,
  output div_cfg_t work,
  output div_cfg_t next_work
);
  div_cfg_t pend;
  logic     pend_vld;
  logic     take;
  logic     apply;

  assign in_ready  = !pend_vld && !blocked;
  assign take      = in_valid && in_ready;
  assign apply     = pend_vld && apply_ok;
  assign next_work = apply ? pend : work;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend     <= CFG_RST;
      work     <= CFG_RST;
    end else begin
      if (take) begin
        pend     <= in_cfg;
        pend_vld <= 1'b1;
      end else if (apply) begin
        pend_vld <= 1'b0;
      end
      if (apply) work <= pend;
    end
  end

  // A pending word is never overwritten before it is applied
  assert_pending_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_vld && !apply_ok) |=> (pend_vld && $stable(pend)));
endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc
  import fnd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [NF_W-1:0] nf,
  input  logic            fmod,
  output logic [NF_W-1:0] frd,
  output logic            steal
);
  logic [Q_W-1:0] q;
  logic [Q_W-1:0] sum;
  logic           wrap;

  assign q    = fmod ? Q_FINE : Q_COARSE;
  assign sum  = {1'b0, frd} + {1'b0, nf};
  assign wrap = (sum >= q);

  always_ff @(posedge clk) begin
    if (rst) begin
      frd   <= '0;
      steal <= 1'b0;
    end else if (step) begin
      frd   <= wrap ? NF_W'(sum - q) : NF_W'(sum);
      steal <= wrap;
    end
  end

  assert_frd_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, frd} < q));

  assert_steal_held_R8: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(steal));
endmodule

// File: rtl/fnd_seg_ctr.sv
module fnd_seg_ctr
  import fnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  div_cfg_t         cur,
  input  logic [NM1_W-1:0] start_nm1,
  input  logic             steal,
  output seg_e             seg,
  output logic [1:0]       mod_ctl,
  output logic             cyc_end,
  output logic             in_last
);
  logic [CNT_W-1:0] cnt;
  logic [NM2_W-1:0] nm2_eff;
  logic             seg_done;
  seg_e             last_seg;
  seg_e             after_seg;

  assign nm2_eff = (cur.pr == 2'b01) ? cur.nm2 : NM2_W'(cur.nm2[NMS_W-1:0]);

  always_comb begin
    case (seg)
      SEG_1:   seg_done = (cnt == (steal ? {CNT_W{1'b1}} : {CNT_W{1'b0}}));
      SEG_2:   seg_done = (cnt == CNT_W'(nm2_eff));
      SEG_3:   seg_done = (cnt == CNT_W'(cur.nm3));
      SEG_4:   seg_done = (cnt == CNT_W'(cur.nm4));
      default: seg_done = 1'b0;
    endcase
  end

  always_comb begin
    case (cur.pr)
      2'b01:   last_seg = SEG_2;
      2'b10:   last_seg = SEG_3;
      default: last_seg = SEG_4;
    endcase
  end

  always_comb begin
    case (seg)
      SEG_1:   after_seg = SEG_2;
      SEG_2:   after_seg = cur.pr[1] ? SEG_3 : SEG_4;
      SEG_3:   after_seg = SEG_4;
      default: after_seg = SEG_1;
    endcase
  end

  always_comb begin
    case (seg)
      SEG_1:   mod_ctl = 2'b10;
      SEG_3:   mod_ctl = 2'b01;
      SEG_4:   mod_ctl = 2'b11;
      default: mod_ctl = 2'b00;
    endcase
  end

  assign cyc_end = seg_done && (seg == last_seg);
  assign in_last = (seg == last_seg);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      seg <= SEG_IDLE;
      cnt <= '0;
    end else if (seg == SEG_IDLE || cyc_end) begin
      seg <= SEG_1;
      cnt <= ~CNT_W'(start_nm1);
    end else if (seg_done) begin
      seg <= after_seg;
      cnt <= (seg == SEG_1 && !steal) ? CNT_W'(1) : '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (mod_ctl == 2'b00 && !cyc_end));

  assert_restart_seg1_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && en) |=> (seg == SEG_1));

  assert_seg1_negative_start_R2: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_1 && $past(seg) != SEG_1) |-> cnt[CNT_W-1]);

  assert_layout_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (seg != SEG_IDLE && !cyc_end) |=> $stable(cur.pr));
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
  import fnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [NM1_W-1:0] cfg_nm1,
  input  logic [NM2_W-1:0] cfg_nm2,
  input  logic [NMS_W-1:0] cfg_nm3,
  input  logic [NMS_W-1:0] cfg_nm4,
  input  logic [1:0]       cfg_pr,
  input  logic [NF_W-1:0]  cfg_nf,
  input  logic             cfg_fmod,
  output logic [1:0]       mod_ctl,
  output logic             div_pulse,
  output logic [NF_W-1:0]  frd,
  output logic             sync_win
);
  div_cfg_t in_cfg;
  div_cfg_t work;
  div_cfg_t next_work;
  seg_e     seg;
  logic     cyc_end;
  logic     in_last;
  logic     steal;

  assign in_cfg = '{nm1: cfg_nm1, nm2: cfg_nm2, nm3: cfg_nm3, nm4: cfg_nm4,
                    pr: cfg_pr, nf: cfg_nf, fmod: cfg_fmod};

  fnd_cfg_stage u_cfg (
    .clk       (clk),
    .rst       (rst),
    .in_cfg    (in_cfg),
    .in_valid  (cfg_valid),
    .in_ready  (cfg_ready),
    .apply_ok  (cyc_end || seg == SEG_IDLE),
    .blocked   (in_last),
    .work      (work),
    .next_work (next_work)
  );

  fnd_seg_ctr u_seg (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cur       (work),
    .start_nm1 (next_work.nm1),
    .steal     (steal),
    .seg       (seg),
    .mod_ctl   (mod_ctl),
    .cyc_end   (cyc_end),
    .in_last   (in_last)
  );

  fnd_frac_acc u_acc (
    .clk   (clk),
    .rst   (rst),
    .step  (cyc_end),
    .nf    (work.nf),
    .fmod  (work.fmod),
    .frd   (frd),
    .steal (steal)
  );

  assign div_pulse = cyc_end;
  assign sync_win  = in_last;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
endmodule

// File: tb/tb_fracn_main_div.sv
`timescale 1ns/1ps
module tb_fracn_main_div;
  logic clk = 1'b0;
  logic rst, en, cfg_valid, cfg_ready, cfg_fmod, div_pulse, sync_win;
  logic [11:0] cfg_nm1;
  logic [7:0]  cfg_nm2;
  logic [3:0]  cfg_nm3, cfg_nm4;
  logic [1:0]  cfg_pr, mod_ctl;
  logic [2:0]  cfg_nf, frd;

  int n_chk = 0, n_fail = 0;
  int m_nm1, m_nm2, m_nm3, m_nm4, m_pr, m_nf, m_fmod, m_acc, m_steal;
  int p_nm1, p_nm2, p_nm3, p_nm4, p_pr, p_nf, p_fmod;
  int tot_w;

  always #2 clk = ~clk;

  fracn_main_div dut (
    .clk(clk), .rst(rst), .en(en), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_nm1(cfg_nm1), .cfg_nm2(cfg_nm2), .cfg_nm3(cfg_nm3), .cfg_nm4(cfg_nm4),
    .cfg_pr(cfg_pr), .cfg_nf(cfg_nf), .cfg_fmod(cfg_fmod),
    .mod_ctl(mod_ctl), .div_pulse(div_pulse), .frd(frd), .sync_win(sync_win)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_p();
    cfg_nm1 = 12'(p_nm1); cfg_nm2 = 8'(p_nm2); cfg_nm3 = 4'(p_nm3);
    cfg_nm4 = 4'(p_nm4); cfg_pr = 2'(p_pr); cfg_nf = 3'(p_nf); cfg_fmod = p_fmod[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; cfg_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_steal = 0; tot_w = 0;
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input int d,
                         input int pr, input int nf, input int fm);
    p_nm1 = a; p_nm2 = b; p_nm3 = c; p_nm4 = d; p_pr = pr; p_nf = nf; p_fmod = fm;
    drive_p();
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    @(negedge clk);
    m_nm1 = a; m_nm2 = b; m_nm3 = c; m_nm4 = d; m_pr = pr; m_nf = nf; m_fmod = fm;
  endtask

  task automatic measure(input bit do_chk, input bit mid_wr);
    int c10 = 0, c00 = 0, c01 = 0, c11 = 0, n = 0;
    int e10, e00, e01, e11, nm2e, lastc, pfrd, pmc, sum, q;
    bit seen = 0, sw = 0, rdy = 0;
    while (!seen) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        chk(1'b0, "R6 watchdog waiting for pulse", n, 0);
        return;
      end
      if (mid_wr && n == 2) begin
        chk(cfg_ready == 1'b1, "R10 ready inside segment one", int'(cfg_ready), 1);
        drive_p();
        cfg_valid = 1'b1;
      end else if (mid_wr && n == 3) begin
        cfg_valid = 1'b0;
      end
      case (mod_ctl)
        2'b10: c10++;
        2'b00: c00++;
        2'b01: c01++;
        default: c11++;
      endcase
      if (div_pulse) begin
        seen = 1; pfrd = int'(frd); sw = sync_win; rdy = cfg_ready; pmc = int'(mod_ctl);
      end
    end
    nm2e  = (m_pr == 1) ? m_nm2 : (m_nm2 % 16);
    e10   = m_nm1 + 2 - m_steal;
    e00   = nm2e + m_steal;
    e01   = (m_pr >= 2) ? m_nm3 + 1 : 0;
    e11   = (m_pr == 3 || m_pr == 0) ? m_nm4 + 1 : 0;
    lastc = (m_pr == 1) ? 0 : (m_pr == 2) ? 1 : 3;
    if (do_chk) begin
      chk(c10 == e10, "R2 R8 segment one length", c10, e10);
      chk(c00 == e00, "R3 R8 segment two length", c00, e00);
      chk(c01 == e01, "R4 segment three length", c01, e01);
      chk(c11 == e11, "R5 final segment length", c11, e11);
      chk(pmc == lastc, "R6 pulse in final segment", pmc, lastc);
      chk(pfrd == m_acc, "R7 accumulator contents", pfrd, m_acc);
      chk(sw && !rdy, "R10 load blocked in final segment", int'(sw) * 2 + int'(rdy), 2);
    end
    tot_w += 4 * c10 + 5 * c00 + 7 * c01 + 9 * c11;
    q = m_fmod ? 8 : 5;
    sum = m_acc + m_nf;
    m_steal = (sum >= q) ? 1 : 0;
    m_acc = m_steal ? sum - q : sum;
    if (mid_wr) begin
      m_nm1 = p_nm1; m_nm2 = p_nm2; m_nm3 = p_nm3; m_nm4 = p_nm4;
      m_pr = p_pr; m_nf = p_nf; m_fmod = p_fmod;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(mod_ctl == 2'b00 && !div_pulse, "R1 outputs quiet after reset",
        int'(mod_ctl) + int'(div_pulse), 0);
    chk(frd == 3'd0, "R1 accumulator cleared", int'(frd), 0);
    chk(cfg_ready && !sync_win, "R1 ready high, window low",
        int'(cfg_ready) * 2 + int'(sync_win), 2);
  endtask

  task automatic t_integer(input int a, input int b, input int c, input int d,
                           input int pr, input int cycles);
    do_reset();
    set_cfg(a, b, c, d, pr, 0, 0);
    en = 1'b1;
    for (int i = 0; i < cycles; i++) measure(1'b1, 1'b0);
  endtask

  task automatic t_fraction(input int a, input int b, input int nf, input int fm);
    int q, n_nom;
    do_reset();
    set_cfg(a, b, 0, 0, 1, nf, fm);
    en = 1'b1;
    q = fm ? 8 : 5;
    measure(1'b1, 1'b0);
    tot_w = 0;
    for (int i = 0; i < q; i++) measure(1'b1, 1'b0);
    n_nom = 4 * (a + 2) + 5 * b;
    chk(tot_w == q * n_nom + nf, "R9 mean ratio over Q cycles", tot_w, q * n_nom + nf);
  endtask

  task automatic t_mid_load();
    do_reset();
    set_cfg(10, 4, 0, 0, 1, 2, 0);
    en = 1'b1;
    measure(1'b1, 1'b0);
    p_nm1 = 20; p_nm2 = 6; p_nm3 = 0; p_nm4 = 0; p_pr = 1; p_nf = 2; p_fmod = 0;
    measure(1'b1, 1'b1);   // R10: this cycle keeps the old word
    measure(1'b1, 1'b0);   // R10: new word governs from here
    measure(1'b1, 1'b0);
  endtask

  task automatic t_enable();
    int bad = 0;
    do_reset();
    set_cfg(8, 5, 0, 0, 1, 3, 0);
    en = 1'b1;
    measure(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      if (mod_ctl != 2'b00 || div_pulse) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R11 idle while disabled", bad, 0);
    chk(int'(frd) == m_acc, "R11 accumulator kept while disabled", int'(frd), m_acc);
    en = 1'b1;
    measure(1'b1, 1'b0);   // R11: full cycle after re-enable
    measure(1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 act=%0d exp=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; cfg_valid = 1'b0;
    p_nm1 = 0; p_nm2 = 1; p_nm3 = 0; p_nm4 = 0; p_pr = 1; p_nf = 0; p_fmod = 0;
    drive_p();
    t_reset();
    t_integer(5, 3, 0, 0, 1, 3);        // R2 R3 two segments
    t_integer(2, 200, 0, 0, 1, 2);      // R3 full-width NM2
    t_integer(4, 8'h35, 3, 0, 2, 2);    // R3 R4 narrow NM2, three segments
    t_integer(3, 2, 2, 6, 3, 2);        // R5 four segments
    t_integer(6, 4, 9, 4, 0, 2);        // R5 NM3 ignored in this layout
    t_fraction(10, 4, 2, 0);            // R7 R8 R9 modulus 5
    t_fraction(6, 3, 3, 1);             // R7 R8 R9 modulus 8
    t_fraction(7, 2, 7, 1);             // R8 steal on most cycles
    t_mid_load();
    t_enable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule